// File: doc/BRIEF.md
# Five-Pin Bidirectional Port Slice with Strobe and Select Takeover

This block is one 8-bit port slice of a controller in which only the low five bit positions reach pins. A small register port, with an address, a read strobe and a write strobe, gives access to two registers:

- **Direction register.** It is write-only. Each bit makes its pin an output (1) or an input (0).
- **Data register.** It is readable. Its three upper bits are fixed at one. A read of the port returns, for each pin, either the stored data bit or the synchronized level seen on the pin.

Each pin has an output-enable and an output-value signal toward the pad.

Two functions can take a pin away from plain I/O:

- **Refresh strobe.** While the refresh-enable input is high, pin 0 carries the external refresh strobe.
- **Chip selects.** Pins 1 to 4 carry external active-low chip-select signals while their direction bits are set. After reset only pin 4 is in this state.

Power handling is governed by a three-state mode machine:

- **MODE_RUN** is normal operation.
- **MODE_SOFT_STBY** keeps both registers and freezes every pin output at the level it had in the cycle before entry.
- **MODE_HARD_STBY** floats all pins and holds both registers at their reset values.

The transitions are as follows:

- **T_HARD_ENTER** goes from any state to MODE_HARD_STBY while `hw_stby` is high.
- **T_SOFT_ENTER** goes from any state to MODE_SOFT_STBY while `sw_stby` is high and `hw_stby` is low.
- **T_RESUME** goes from any state to MODE_RUN when both inputs are low.

`hw_stby` always wins over `sw_stby`.

Top module: `gpio_port_slice`

## Requirements
- R1: With refresh disabled in MODE_RUN, pin 0 drives (pin_oe[0]=1, pin_out[0]=data bit 0) when direction bit 0 is 1, and floats (pin_oe[0]=0, pin_out[0]=0) when it is 0.
- R2: A read of the direction register (bus_addr=0) returns 8'hFF whatever has been written.
- R3: After reset and after any cycle with hw_stby high, the direction register holds 5'b10000 and the data register holds 5'b00000, so a data read with all pins low returns 8'hE0.
- R4: Data register bits 7 to 5 always read as 1, and writes to them have no effect.
- R5: A data read (bus_addr=1) returns, for each pin k in 0..4, data bit k when direction bit k is 1. Otherwise it returns pin_in[k] as sampled by two clock edges of synchronization.
- R6: In MODE_RUN with rfsh_en=1, pin 0 is enabled and pin_out[0] follows rfsh_strobe, whatever direction bit 0 holds.
- R7: In MODE_RUN, pin k in 1..4 whose direction bit is 1 is enabled and drives cs_n[k-1]. With the bit at 0 it floats with output value 0.
- R8: In MODE_SOFT_STBY, pin_oe and pin_out hold the values of the last cycle before entry, writes are ignored, and both registers keep their contents through the standby.
- R9: hw_stby forces MODE_HARD_STBY at the next edge even when sw_stby is high. In that mode all pins float, and a write presented while hw_stby is high is lost.
- R10: A write accepted in MODE_RUN changes the register at the next clock edge. bus_rdata is combinational in the same cycle, and is 0 when bus_rd is low or the address is 2 or 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_stby | input | 1 | Hardware standby request, highest priority |
| sw_stby | input | 1 | Software standby request |
| bus_addr | input | 2 | Register select: 0 direction, 1 data |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| pin_in | input | 5 | Pad input levels, asynchronous |
| pin_oe | output | 5 | Per-pin output enable |
| pin_out | output | 5 | Per-pin output value |
| rfsh_en | input | 1 | Refresh-strobe takeover of pin 0 |
| rfsh_strobe | input | 1 | Refresh strobe from the refresh logic |
| cs_n | input | 4 | Chip-select levels for pins 1 to 4 |

## Verification
The hardest case is a standby entry on a cycle where the pin outputs have just changed. The frozen value must be the previous cycle's output, not the current one. The stimulus changes cs_n, rfsh_strobe and the registers on the very cycle sw_stby rises, and again on a cycle where hw_stby falls while sw_stby is still high. The second case gives a direct move from MODE_HARD_STBY to MODE_SOFT_STBY, which must freeze floating pins. A per-cycle behavioural model, run alongside a constrained random phase, compares every output on every clock.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    typedef enum logic [1:0] {
        MODE_RUN       = 2'd0,
        MODE_SOFT_STBY = 2'd1,
        MODE_HARD_STBY = 2'd2
    } port_mode_e;
endpackage

// File: rtl/gpio_mode_fsm.sv
module gpio_mode_fsm
    import gpio_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hw_stby,
    input  logic       sw_stby,
    output port_mode_e mode_q,
    output logic       wr_allow,
    output logic       pads_hold,
    output logic       pads_off
);
    port_mode_e mode_d;

    // next-state decision: T_HARD_ENTER > T_SOFT_ENTER > T_RESUME
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_RUN: begin
                if (hw_stby)      mode_d = MODE_HARD_STBY;
                else if (sw_stby) mode_d = MODE_SOFT_STBY;
                else              mode_d = MODE_RUN;
            end
            MODE_SOFT_STBY: begin
                if (hw_stby)      mode_d = MODE_HARD_STBY;
                else if (sw_stby) mode_d = MODE_SOFT_STBY;
                else              mode_d = MODE_RUN;
            end
            MODE_HARD_STBY: begin
                if (hw_stby)      mode_d = MODE_HARD_STBY;
                else if (sw_stby) mode_d = MODE_SOFT_STBY;
                else              mode_d = MODE_RUN;
            end
            default: mode_d = MODE_HARD_STBY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_RUN;
        else        mode_q <= mode_d;
    end

    always_comb begin
        wr_allow  = 1'b0;
        pads_hold = 1'b0;
        pads_off  = 1'b0;
        unique case (mode_q)
            MODE_RUN:       wr_allow  = !hw_stby && !sw_stby;
            MODE_SOFT_STBY: pads_hold = 1'b1;
            MODE_HARD_STBY: pads_off  = 1'b1;
            default:        pads_off  = 1'b1;
        endcase
    end

    assert_hw_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hw_stby |=> (mode_q == MODE_HARD_STBY));
    assert_soft_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_stby && !hw_stby) |=> (mode_q == MODE_SOFT_STBY));
endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int WIDTH = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1   <= '0;
            sync_out <= '0;
        end else begin
            stage1   <= async_in;
            sync_out <= stage1;
        end
    end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
    parameter int          NUM_PINS  = 5,
    parameter int          REG_W     = 8,
    parameter int          ADDR_W    = 2,
    parameter int          DIR_ADDR  = 0,
    parameter int          DATA_ADDR = 1,
    parameter logic [7:0]  DIR_INIT  = 8'hF0,
    parameter logic [7:0]  DATA_INIT = 8'hE0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hw_stby,
    input  logic                wr_allow,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [REG_W-1:0]    bus_wdata,
    output logic [NUM_PINS-1:0] dir_q,
    output logic [NUM_PINS-1:0] data_q
);
    localparam logic [NUM_PINS-1:0] DIR_RST  = DIR_INIT[NUM_PINS-1:0];
    localparam logic [NUM_PINS-1:0] DATA_RST = DATA_INIT[NUM_PINS-1:0];

    logic unused_wdata_hi;
    assign unused_wdata_hi = ^bus_wdata[REG_W-1:NUM_PINS];

    logic take_dir, take_data;
    assign take_dir  = wr_allow && bus_wr && (bus_addr == ADDR_W'(DIR_ADDR));
    assign take_data = wr_allow && bus_wr && (bus_addr == ADDR_W'(DATA_ADDR));

    always_ff @(posedge clk) begin
        if (!rst_n || hw_stby) begin
            dir_q  <= DIR_RST;
            data_q <= DATA_RST;
        end else begin
            if (take_dir)  dir_q  <= bus_wdata[NUM_PINS-1:0];
            if (take_data) data_q <= bus_wdata[NUM_PINS-1:0];
        end
    end

    assert_hw_reinit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hw_stby |=> (dir_q == DIR_RST && data_q == DATA_RST));
    assert_write_next_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_allow && bus_wr && !hw_stby && bus_addr == ADDR_W'(DATA_ADDR))
        |=> (data_q == $past(bus_wdata[NUM_PINS-1:0])));
    assert_regs_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_allow && !hw_stby) |=> ($stable(dir_q) && $stable(data_q)));
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
    parameter int NUM_PINS = 5,
    parameter int RFSH_PIN = 0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] dir_q,
    input  logic [NUM_PINS-1:0] data_q,
    input  logic                rfsh_en,
    input  logic                rfsh_strobe,
    input  logic [NUM_PINS-2:0] cs_n,
    input  logic                pads_hold,
    input  logic                pads_off,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic [NUM_PINS-1:0] pin_out
);
    logic [NUM_PINS-1:0] live_oe, live_out;
    logic [NUM_PINS-1:0] cur_oe, cur_out;
    logic [NUM_PINS-1:0] hold_oe, hold_out;

    for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin
        if (k == RFSH_PIN) begin : g_rfsh
            always_comb begin
                if (rfsh_en) begin
                    live_oe[k]  = 1'b1;
                    live_out[k] = rfsh_strobe;
                end else begin
                    live_oe[k]  = dir_q[k];
                    live_out[k] = dir_q[k] & data_q[k];
                end
            end
        end else begin : g_cs
            localparam int CS_IDX = (k < RFSH_PIN) ? k : k - 1;
            assign live_oe[k]  = dir_q[k];
            assign live_out[k] = dir_q[k] & cs_n[CS_IDX];
        end
    end

    assign cur_oe  = pads_off ? '0 : live_oe;
    assign cur_out = pads_off ? '0 : live_out;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_oe  <= '0;
            hold_out <= '0;
        end else if (!pads_hold) begin
            hold_oe  <= cur_oe;
            hold_out <= cur_out;
        end
    end

    assign pin_oe  = pads_hold ? hold_oe  : cur_oe;
    assign pin_out = pads_hold ? hold_out : cur_out;

    assert_pads_float_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pads_off |-> (pin_oe == '0));
    assert_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pads_hold |-> (pin_oe == $past(pin_oe) && pin_out == $past(pin_out)));
    assert_rfsh_owns_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!pads_hold && !pads_off && rfsh_en)
        |-> (pin_oe[RFSH_PIN] && pin_out[RFSH_PIN] == rfsh_strobe));
endmodule

// File: rtl/gpio_port_slice.sv
module gpio_port_slice
    import gpio_port_pkg::*;
#(
    parameter int         NUM_PINS  = 5,
    parameter int         REG_W     = 8,
    parameter int         ADDR_W    = 2,
    parameter int         DIR_ADDR  = 0,
    parameter int         DATA_ADDR = 1,
    parameter int         RFSH_PIN  = 0,
    parameter logic [7:0] DIR_INIT  = 8'hF0,
    parameter logic [7:0] DATA_INIT = 8'hE0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hw_stby,
    input  logic                sw_stby,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_rd,
    input  logic                bus_wr,
    input  logic [REG_W-1:0]    bus_wdata,
    output logic [REG_W-1:0]    bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic [NUM_PINS-1:0] pin_out,
    input  logic                rfsh_en,
    input  logic                rfsh_strobe,
    input  logic [NUM_PINS-2:0] cs_n
);
    port_mode_e          mode_q;
    logic                wr_allow, pads_hold, pads_off;
    logic [NUM_PINS-1:0] dir_q, data_q, pin_sync;
    logic [REG_W-1:0]    port_view;

    gpio_pin_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(pin_sync)
    );

    gpio_mode_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .sw_stby(sw_stby),
        .mode_q(mode_q), .wr_allow(wr_allow), .pads_hold(pads_hold),
        .pads_off(pads_off)
    );

    gpio_port_regs #(
        .NUM_PINS(NUM_PINS), .REG_W(REG_W), .ADDR_W(ADDR_W),
        .DIR_ADDR(DIR_ADDR), .DATA_ADDR(DATA_ADDR),
        .DIR_INIT(DIR_INIT), .DATA_INIT(DATA_INIT)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .wr_allow(wr_allow),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .dir_q(dir_q), .data_q(data_q)
    );

    gpio_pin_mux #(.NUM_PINS(NUM_PINS), .RFSH_PIN(RFSH_PIN)) u_mux (
        .clk(clk), .rst_n(rst_n), .dir_q(dir_q), .data_q(data_q),
        .rfsh_en(rfsh_en), .rfsh_strobe(rfsh_strobe), .cs_n(cs_n),
        .pads_hold(pads_hold), .pads_off(pads_off),
        .pin_oe(pin_oe), .pin_out(pin_out)
    );

    always_comb begin
        port_view = '1;
        for (int k = 0; k < NUM_PINS; k++)
            port_view[k] = dir_q[k] ? data_q[k] : pin_sync[k];
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (bus_addr == ADDR_W'(DIR_ADDR))       bus_rdata = '1;
            else if (bus_addr == ADDR_W'(DATA_ADDR)) bus_rdata = port_view;
        end
    end

    assert_dir_reads_ones_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(DIR_ADDR)) |-> (bus_rdata == '1));
    assert_reserved_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(DATA_ADDR))
        |-> (bus_rdata[REG_W-1:NUM_PINS] == '1));
    assert_read_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(DATA_ADDR) && !dir_q[0])
        |-> (bus_rdata[0] == $past(pin_in[0], 2)));
    assert_idle_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == '0));
endmodule

// File: tb/gpio_port_slice_tb.sv
module gpio_port_slice_tb;
    localparam int NP = 5;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n, hw_stby, sw_stby, bus_rd, bus_wr, rfsh_en, rfsh_strobe;
    logic [1:0]    bus_addr;
    logic [7:0]    bus_wdata, bus_rdata;
    logic [NP-1:0] pin_in, pin_oe, pin_out;
    logic [NP-2:0] cs_n;

    gpio_port_slice u_dut (
        .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .sw_stby(sw_stby),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_oe(pin_oe), .pin_out(pin_out), .rfsh_en(rfsh_en),
        .rfsh_strobe(rfsh_strobe), .cs_n(cs_n)
    );

    // behavioural reference: 0 run, 1 soft standby, 2 hard standby
    int            m_mode;
    logic [NP-1:0] m_dir, m_data, m_s1, m_s2, m_hoe, m_hout;
    int            vectors = 0, miscompares = 0, cycles = 0;
    string         phase = "R3";

    function automatic void live(output logic [NP-1:0] oe, output logic [NP-1:0] o);
        oe = '0; o = '0;
        if (m_mode != 2) begin
            if (rfsh_en) begin oe[0] = 1'b1; o[0] = rfsh_strobe; end
            else if (m_dir[0]) begin oe[0] = 1'b1; o[0] = m_data[0]; end
            for (int k = 1; k < NP; k++)
                if (m_dir[k]) begin oe[k] = 1'b1; o[k] = cs_n[k-1]; end
        end
    endfunction

    function automatic logic [7:0] exp_rd();
        logic [7:0] v;
        v = 8'h00;
        if (bus_rd) begin
            if (bus_addr == 2'd0) v = 8'hFF;
            else if (bus_addr == 2'd1) begin
                v = 8'hE0;
                for (int k = 0; k < NP; k++) v[k] = m_dir[k] ? m_data[k] : m_s2[k];
            end
        end
        return v;
    endfunction

    always @(posedge clk) begin
        logic [NP-1:0] c_oe, c_o;
        cycles++;
        if (!rst_n) begin
            m_mode = 0; m_dir = 5'b10000; m_data = '0;
            m_s1 = '0; m_s2 = '0; m_hoe = '0; m_hout = '0;
        end else begin
            live(c_oe, c_o);
            if (m_mode != 1) begin m_hoe = c_oe; m_hout = c_o; end
            m_s2 = m_s1; m_s1 = pin_in;
            if (hw_stby) begin m_dir = 5'b10000; m_data = '0; end
            else if (bus_wr && m_mode == 0 && !sw_stby) begin
                if (bus_addr == 2'd0) m_dir  = bus_wdata[NP-1:0];
                if (bus_addr == 2'd1) m_data = bus_wdata[NP-1:0];
            end
            m_mode = hw_stby ? 2 : (sw_stby ? 1 : 0);
        end
    end

    task automatic compare();
        logic [NP-1:0] e_oe, e_o;
        logic [7:0]    e_rd;
        if (m_mode == 1) begin e_oe = m_hoe; e_o = m_hout; end
        else live(e_oe, e_o);
        e_rd = exp_rd();
        vectors++;
        if (pin_oe !== e_oe || pin_out !== e_o || bus_rdata !== e_rd) begin
            miscompares++;
            $display("FAIL %s t=%0t oe=%b out=%b rd=%h expected oe=%b out=%b rd=%h",
                     phase, $time, pin_oe, pin_out, bus_rdata, e_oe, e_o, e_rd);
        end
    endtask

    task automatic cyc();
        #1;
        if (rst_n) compare();
        @(negedge clk);
    endtask

    task automatic fixed_rd(input logic [1:0] a, input logic [7:0] e, input string tag);
        bus_rd = 1'b1; bus_addr = a; bus_wr = 1'b0;
        #1;
        vectors++;
        if (bus_rdata !== e) begin
            miscompares++;
            $display("FAIL %s fixed read addr=%0d actual=%h expected=%h", tag, a, bus_rdata, e);
        end
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_rd = 1'b0; bus_addr = a; bus_wdata = d;
        cyc();
        bus_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    always @(posedge clk) if (cycles > 100000) begin
        miscompares++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; hw_stby = 0; sw_stby = 0; bus_rd = 0; bus_wr = 0;
        bus_addr = 0; bus_wdata = 0; pin_in = 0; rfsh_en = 0; rfsh_strobe = 0;
        cs_n = 4'hF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R3 reset values, R2 direction read-back
        phase = "R3"; idle(2);
        fixed_rd(2'd1, 8'hE0, "R3");
        fixed_rd(2'd0, 8'hFF, "R2");
        // R7 pin 4 owned by chip select after reset
        phase = "R7"; bus_rd = 0; cs_n = 4'b0111; cyc(); cs_n = 4'b1000; cyc();
        // R1 pin 0 direction, R10 write lands next edge
        phase = "R1"; wr(2'd1, 8'h1F); wr(2'd0, 8'h01); idle(2);
        wr(2'd1, 8'h00); cyc(); wr(2'd0, 8'h00); cyc();
        // R2 write of zeros still reads ones
        fixed_rd(2'd0, 8'hFF, "R2");
        // R5 pin levels through synchronizer
        phase = "R5"; bus_rd = 1; bus_addr = 2'd1;
        pin_in = 5'b10101; cyc(); cyc(); cyc();
        pin_in = 5'b01010; idle(3);
        bus_wr = 1; bus_wdata = 8'h05; bus_addr = 2'd0; cyc();
        bus_wr = 0; bus_addr = 2'd1; idle(2);
        // R4 reserved bits stuck at one
        phase = "R4"; wr(2'd1, 8'h00); fixed_rd(2'd1, 8'hE0 | {3'b0, 5'b01010 & ~5'b00101}, "R4");
        wr(2'd1, 8'hE7); bus_rd = 1; bus_addr = 2'd1; idle(2);
        // R6 refresh strobe takeover
        phase = "R6"; bus_rd = 0; wr(2'd0, 8'h00); rfsh_en = 1;
        for (int i = 0; i < 6; i++) begin rfsh_strobe = i[0]; cyc(); end
        wr(2'd0, 8'h01); rfsh_strobe = 1; cyc(); rfsh_en = 0; idle(2);
        // R7 all chip selects
        phase = "R7"; wr(2'd0, 8'h1E);
        for (int i = 0; i < 6; i++) begin cs_n = 4'(i * 5); cyc(); end
        // R8 software standby with changes on entry cycle
        phase = "R8"; wr(2'd1, 8'h01); wr(2'd0, 8'h1F);
        sw_stby = 1; cs_n = 4'b0101; bus_wr = 1; bus_addr = 2'd1; bus_wdata = 8'h00; cyc();
        cs_n = 4'b1010; rfsh_en = 1; rfsh_strobe = 0; cyc(); bus_addr = 2'd0; cyc();
        bus_wr = 0; idle(3);
        sw_stby = 0; rfsh_en = 0; cyc();
        bus_rd = 1; bus_addr = 2'd1; pin_in = 0; idle(3);
        // R9 hardware standby: priority, write lost, then direct to soft standby
        phase = "R9"; bus_rd = 0; hw_stby = 1; sw_stby = 1;
        bus_wr = 1; bus_addr = 2'd0; bus_wdata = 8'h1F; cyc();
        bus_wr = 0; idle(3);
        hw_stby = 0; cyc(); cyc();
        sw_stby = 0; cyc();
        fixed_rd(2'd1, 8'hE0, "R9");
        // R10 unmapped and idle reads
        phase = "R10"; fixed_rd(2'd2, 8'h00, "R10"); fixed_rd(2'd3, 8'h00, "R10");
        bus_rd = 0; bus_addr = 2'd0; cyc();
        // mixed random traffic against the model
        phase = "R10";
        for (int i = 0; i < 400; i++) begin
            bus_rd = 1'($urandom); bus_wr = 1'($urandom); bus_addr = 2'($urandom);
            bus_wdata = 8'($urandom); pin_in = 5'($urandom); cs_n = 4'($urandom);
            rfsh_en = ($urandom % 4) == 0; rfsh_strobe = 1'($urandom);
            sw_stby = ($urandom % 8) == 0; hw_stby = ($urandom % 16) == 0;
            cyc();
        end
        finish_run();
    end
endmodule